// File: doc/BRIEF.md
# Serial Controller Status and Control Register File

This block is the register bank of a FIFO-based serial controller. It stores the
mode, bit-rate, line control, FIFO control and port settings, each byte wide and
placed on a four-byte stride. Each setting keeps only the bits its mask allows. Five
status flags track transmit completion, transmit buffer space, a received break,
receive FIFO readiness and pending receive data. Software clears a flag by writing a
zero to its bit. Hardware events from the FIFO and line logic set the flags.

A processor-side bus reaches the bank through an address, write data and separate
write and read strobes. Read data is combinational from the address. The receive
byte and the receive FIFO level come from the external datapath and are only muxed
onto the read bus here. A receive interrupt line and a transmit interrupt line are
produced from the control enables and the flag activity.

Top module: `sercsr_top`

## Requirements
- R1: After reset, mode reads 0x00, bit-rate reads 0xFF, control reads 0x20, FIFO control and port read 0x00, status reads 0x60, and both interrupt lines are low.
- R2: The status byte (offset 0x10) carries transmit end on bit 6, transmit buffer empty on bit 5, break on bit 4, receive ready on bit 1 and data ready on bit 0. Bits 7, 3 and 2 read 0. The break, receive-ready and data-ready event inputs each set their flag on the cycle after a one-cycle pulse.
- R3: A status write clears every flag whose bit is 0 in the written byte and leaves every flag whose bit is 1 unchanged.
- R4: When a set event and a clearing status write reach the same flag in one cycle, the flag ends up set.
- R5: Writes keep only the allowed bits: mode keeps 0x7B, control keeps 0xFA, port keeps 0xF3, and bit-rate (0x04) and FIFO control (0x18) keep all eight bits. Offsets are mode 0x00 and control 0x08, port 0x20.
- R6: A write to the transmit data offset 0x0C clears the transmit buffer empty flag.
- R7: A control write with bit 5 (transmitter enable) at 0 sets the transmit end flag.
- R8: A status read returns the flags as they stood before the read. If control bit 5 is 1 during that read, transmit end and transmit buffer empty are both 1 on the next cycle. If bit 5 is 0, the read has no effect.
- R9: The receive interrupt rises on the cycle after a receive-ready pulse while control bit 6 is 1. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0.
- R10: The transmit interrupt equals control bit 7 and follows a control write on the next cycle.
- R11: Offset 0x14 returns the receive byte input and offset 0x1C returns the FIFO level input. The line-status offset 0x24 and the transmit data offset read 0. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte offset of the accessed register |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| evt_break | input | 1 | Break detected on the line (pulse) |
| evt_rx_ready | input | 1 | Receive FIFO reached its trigger level (pulse) |
| evt_data_ready | input | 1 | Received data is pending (pulse) |
| rx_byte | input | 8 | Head byte of the receive FIFO |
| rx_level | input | 8 | Number of bytes in the receive FIFO |
| rdata | output | 8 | Read data for the current address |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that every strobe and event is synchronous to `clk`. They also assume that the address and write data stay stable during any cycle in which a strobe is high. A read's side effect is checked on the edge that ends the strobe cycle, so the checks expect at most one access per cycle. The stimulus drives every input on the falling edge, raises each strobe for exactly one cycle, and pulses events for one cycle. The one exception is the set-wins case, where an event pulse and a status write share a cycle on purpose.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    parameter int ADDR_W = 6;
    parameter int DATA_W = 8;
    localparam int NUM_CFG = 5;

    // configuration register slots
    localparam int CFG_MODE = 0;
    localparam int CFG_RATE = 1;
    localparam int CFG_CTRL = 2;
    localparam int CFG_FIFO = 3;
    localparam int CFG_PORT = 4;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RATE  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_FIFO  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_PORT  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_LINE  = 6'h24;

    localparam logic [ADDR_W-1:0] CFG_OFS   [NUM_CFG] = '{OFS_MODE, OFS_RATE, OFS_CTRL, OFS_FIFO, OFS_PORT};
    localparam logic [DATA_W-1:0] CFG_MASK  [NUM_CFG] = '{8'h7B, 8'hFF, 8'hFA, 8'hFF, 8'hF3};
    localparam logic [DATA_W-1:0] CFG_RESET [NUM_CFG] = '{8'h00, 8'hFF, 8'h20, 8'h00, 8'h00};

    // status byte bit positions
    localparam int ST_TEND = 6;
    localparam int ST_TDE  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_RDF  = 1;
    localparam int ST_DR   = 0;

    // control byte bit positions
    localparam int CB_TXIE = 7;
    localparam int CB_RXIE = 6;
    localparam int CB_TXEN = 5;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
        logic irq_rx;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{tend: 1'b1, tde: 1'b1, brk: 1'b0,
                                           rdf: 1'b0, dr: 1'b0, irq_rx: 1'b0};

endpackage

// File: rtl/sercsr_cfgregs.sv
module sercsr_cfgregs
    import sercsr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            wr_en,
    output logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_q
);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        logic              hit;
        logic [DATA_W-1:0] val_d;
        logic [DATA_W-1:0] val_q;

        always_comb begin
            hit   = wr_en && (addr == CFG_OFS[g]);
            val_d = val_q;
            if (hit) begin
                val_d = wdata & CFG_MASK[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= CFG_RESET[g];
            end else begin
                val_q <= val_d;
            end
        end

        assign cfg_q[g] = val_q;

        // R5: a write keeps exactly the allowed bits
        a_r5_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CFG_OFS[g]) |=> (val_q == $past(wdata & CFG_MASK[g])));
    end

endmodule

// File: rtl/sercsr_flags.sv
module sercsr_flags
    import sercsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              stat_rd,
    input  logic              ctrl_wr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctrl_txen,
    input  logic              ctrl_rxie,
    input  logic              evt_break,
    input  logic              evt_rx_ready,
    input  logic              evt_data_ready,
    output logic [DATA_W-1:0] status,
    output logic              irq_rx
);

    flag_state_t st_d;
    flag_state_t st_q;

    logic refill;
    logic rx_clr;

    always_comb begin
        st_d   = st_q;
        refill = stat_rd && ctrl_txen;
        rx_clr = (stat_wr && (!wdata[ST_RDF] || !wdata[ST_DR]))
              || (ctrl_wr && !wdata[CB_RXIE]);

        // clears first, sets afterwards so a same-cycle set wins
        if (stat_wr) begin
            if (!wdata[ST_TEND]) st_d.tend = 1'b0;
            if (!wdata[ST_TDE])  st_d.tde  = 1'b0;
            if (!wdata[ST_BRK])  st_d.brk  = 1'b0;
            if (!wdata[ST_RDF])  st_d.rdf  = 1'b0;
            if (!wdata[ST_DR])   st_d.dr   = 1'b0;
        end
        if (tx_wr)  st_d.tde    = 1'b0;
        if (rx_clr) st_d.irq_rx = 1'b0;

        if (ctrl_wr && !wdata[CB_TXEN]) st_d.tend = 1'b1;
        if (refill) begin
            st_d.tend = 1'b1;
            st_d.tde  = 1'b1;
        end
        if (evt_break)      st_d.brk = 1'b1;
        if (evt_data_ready) st_d.dr  = 1'b1;
        if (evt_rx_ready) begin
            st_d.rdf = 1'b1;
            if (ctrl_rxie) st_d.irq_rx = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_TEND] = st_q.tend;
        status[ST_TDE]  = st_q.tde;
        status[ST_BRK]  = st_q.brk;
        status[ST_RDF]  = st_q.rdf;
        status[ST_DR]   = st_q.dr;
    end

    assign irq_rx = st_q.irq_rx;

    // R3: transmit end only drops after a status write with its bit at zero
    a_r3_tend_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.tend) |-> $past(stat_wr && !wdata[ST_TEND]));

    // R4: a break event always leaves the break flag set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_break |=> st_q.brk);

    // R6: a transmit data write empties the buffer flag unless a refill read coincides
    a_r6_txd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !(stat_rd && ctrl_txen)) |=> !st_q.tde);

    // R8: status read with transmitter enabled refills both transmit flags
    a_r8_read_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ctrl_txen) |=> (st_q.tend && st_q.tde));

    // R9: the receive interrupt rises only from an enabled receive-ready event
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq_rx) |-> $past(evt_rx_ready && ctrl_rxie));

endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
    import sercsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              evt_break,
    input  logic              evt_rx_ready,
    input  logic              evt_data_ready,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rx_level,
    output logic [7:0]        rdata,
    output logic              irq_rx,
    output logic              irq_tx
);

    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0]              status;
    logic                           stat_wr;
    logic                           stat_rd;
    logic                           ctrl_wr;
    logic                           tx_wr;

    always_comb begin
        stat_wr = wr_en && (addr == OFS_STAT);
        stat_rd = rd_en && (addr == OFS_STAT);
        ctrl_wr = wr_en && (addr == OFS_CTRL);
        tx_wr   = wr_en && (addr == OFS_TXD);
    end

    sercsr_cfgregs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .cfg_q (cfg_q)
    );

    sercsr_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .stat_wr        (stat_wr),
        .stat_rd        (stat_rd),
        .ctrl_wr        (ctrl_wr),
        .tx_wr          (tx_wr),
        .wdata          (wdata),
        .ctrl_txen      (cfg_q[CFG_CTRL][CB_TXEN]),
        .ctrl_rxie      (cfg_q[CFG_CTRL][CB_RXIE]),
        .evt_break      (evt_break),
        .evt_rx_ready   (evt_rx_ready),
        .evt_data_ready (evt_data_ready),
        .status         (status),
        .irq_rx         (irq_rx)
    );

    assign irq_tx = cfg_q[CFG_CTRL][CB_TXIE];

    always_comb begin
        unique case (addr)
            OFS_MODE:  rdata = cfg_q[CFG_MODE];
            OFS_RATE:  rdata = cfg_q[CFG_RATE];
            OFS_CTRL:  rdata = cfg_q[CFG_CTRL];
            OFS_FIFO:  rdata = cfg_q[CFG_FIFO];
            OFS_PORT:  rdata = cfg_q[CFG_PORT];
            OFS_STAT:  rdata = status;
            OFS_RXD:   rdata = rx_byte;
            OFS_LEVEL: rdata = rx_level;
            OFS_LINE:  rdata = '0;
            default:   rdata = '0;
        endcase
    end

    // R10: transmit interrupt takes the written control bit 7 on the next cycle
    a_r10_irq_tx_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (irq_tx == $past(wdata[CB_TXIE])));

    // R2: unused status bits never read as one
    a_r2_status_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_STAT) |-> (rdata[7] == 1'b0 && rdata[3:2] == 2'b00));

    // R11: line status offset always reads zero
    a_r11_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_LINE) |-> (rdata == 8'h00));

    // R7: a control write clearing the enable leaves transmit end set
    a_r7_txen_off_tend: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[CB_TXEN]) |=> status[ST_TEND]);

endmodule

// File: tb/tb_sercsr_top.sv
module tb_sercsr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       evt_break = 1'b0;
    logic       evt_rx_ready = 1'b0;
    logic       evt_data_ready = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rx_level = '0;
    logic [7:0] rdata;
    logic       irq_rx;
    logic       irq_tx;

    int checks = 0;
    int failures = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    sercsr_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .evt_break(evt_break),
        .evt_rx_ready(evt_rx_ready), .evt_data_ready(evt_data_ready),
        .rx_byte(rx_byte), .rx_level(rx_level), .rdata(rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    typedef struct packed {
        logic       is_wr;
        logic [5:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h00, 8'hFF, 8'd5},
        '{1'b0, 6'h00, 8'h7B, 8'd5},   // R5 mode mask
        '{1'b1, 6'h08, 8'hFF, 8'd5},
        '{1'b0, 6'h08, 8'hFA, 8'd5},   // R5 control mask
        '{1'b1, 6'h20, 8'hFF, 8'd5},
        '{1'b0, 6'h20, 8'hF3, 8'd5},   // R5 port mask
        '{1'b1, 6'h04, 8'h5A, 8'd5},
        '{1'b0, 6'h04, 8'h5A, 8'd5},
        '{1'b1, 6'h18, 8'hC3, 8'd5},
        '{1'b0, 6'h18, 8'hC3, 8'd5},
        '{1'b1, 6'h28, 8'hFF, 8'd11},
        '{1'b0, 6'h28, 8'h00, 8'd11},  // R11 unmapped
        '{1'b0, 6'h24, 8'h00, 8'd11},  // R11 line status
        '{1'b0, 6'h0C, 8'h00, 8'd11},
        '{1'b1, 6'h10, 8'h00, 8'd3},
        '{1'b0, 6'h10, 8'h00, 8'd3},   // R3 clear all
        '{1'b0, 6'h10, 8'h60, 8'd8},   // R8 refill seen
        '{1'b1, 6'h0C, 8'h41, 8'd6},
        '{1'b0, 6'h10, 8'h40, 8'd6},   // R6
        '{1'b1, 6'h10, 8'hDF, 8'd3},
        '{1'b0, 6'h10, 8'h40, 8'd3},   // R3 selective clear
        '{1'b1, 6'h08, 8'h00, 8'd8},
        '{1'b1, 6'h10, 8'h00, 8'd8},
        '{1'b0, 6'h10, 8'h00, 8'd8},
        '{1'b0, 6'h10, 8'h00, 8'd8},   // R8 no refill when disabled
        '{1'b1, 6'h08, 8'h40, 8'd7},
        '{1'b0, 6'h10, 8'h40, 8'd7}    // R7
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic b, input logic r, input logic d);
        @(negedge clk);
        evt_break = b; evt_rx_ready = r; evt_data_ready = d;
        @(negedge clk);
        evt_break = 1'b0; evt_rx_ready = 1'b0; evt_data_ready = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, got); check(got, 8'h00, "R1 mode");
        rd(6'h04, got); check(got, 8'hFF, "R1 rate");
        rd(6'h08, got); check(got, 8'h20, "R1 ctrl");
        rd(6'h18, got); check(got, 8'h00, "R1 fifo");
        rd(6'h20, got); check(got, 8'h00, "R1 port");
        rd(6'h10, got); check(got, 8'h60, "R1 status");
        check({7'd0, irq_rx}, 8'h00, "R1 irq_rx");
        check({7'd0, irq_tx}, 8'h00, "R1 irq_tx");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                wr(VECS[i].a, VECS[i].d);
            end else begin
                rd(VECS[i].a, got);
                check(got, VECS[i].d, $sformatf("R%0d vector %0d", VECS[i].req, i));
            end
        end
        // control now 0x40 (receive interrupt enabled, transmitter off)

        // R2 event pulses set flags at their bit positions
        wr(6'h10, 8'h00);
        pulse(1'b1, 1'b1, 1'b1);
        check({7'd0, irq_rx}, 8'h01, "R9 irq_rx raised");
        rd(6'h10, got); check(got, 8'h13, "R2 status layout");
        wr(6'h10, 8'hFE);
        check({7'd0, irq_rx}, 8'h00, "R9 irq_rx cleared by status bit0");
        rd(6'h10, got); check(got, 8'h12, "R3 clear data ready");
        wr(6'h10, 8'hEF);
        rd(6'h10, got); check(got, 8'h02, "R3 clear break");

        // R4 set wins over same-cycle clear
        @(negedge clk);
        addr = 6'h10; wdata = 8'h00; wr_en = 1'b1; evt_break = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; evt_break = 1'b0;
        rd(6'h10, got); check(got, 8'h10, "R4 break survives clear");

        // R9 control bit 6 clears and gates the receive interrupt
        pulse(1'b0, 1'b1, 1'b0);
        check({7'd0, irq_rx}, 8'h01, "R9 irq_rx raised again");
        wr(6'h08, 8'h00);
        check({7'd0, irq_rx}, 8'h00, "R9 irq_rx cleared by control");
        pulse(1'b0, 1'b1, 1'b0);
        check({7'd0, irq_rx}, 8'h00, "R9 irq_rx gated off");
        rd(6'h10, got); check(got, 8'h52, "R9 ready flag still set");

        // R10 transmit interrupt follows control bit 7
        wr(6'h08, 8'h80);
        check({7'd0, irq_tx}, 8'h01, "R10 irq_tx high");
        wr(6'h08, 8'h00);
        check({7'd0, irq_tx}, 8'h00, "R10 irq_tx low");

        // R11 pass-through of receive byte and level
        rx_byte = 8'hA5; rx_level = 8'h07;
        rd(6'h14, got); check(got, 8'hA5, "R11 receive byte");
        rd(6'h1C, got); check(got, 8'h07, "R11 receive level");

        // R8 value returned is the pre-read state
        wr(6'h08, 8'h20);
        wr(6'h10, 8'h00);
        rd(6'h10, got); check(got, 8'h00, "R8 pre-read value");
        rd(6'h10, got); check(got, 8'h60, "R8 refilled");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule